// File: doc/BRIEF.md
# Configurable-Order Sinc Decimator

This block turns a single-channel 1-bit pulse-density stream into signed 24-bit PCM samples. It uses a cascaded integrator-comb filter. Each accepted input bit counts as +1 or -1. The bit passes through N cascaded integrators running at the input rate. At every R-th accepted bit the integrator result passes through N cascaded first-difference combs. The result is then scaled so that a constant full-scale input lands on the 24-bit full scale.

The filter order N (1 to 5) and the ratio code (R = 8 to 256) are sampled only when the enable rises. Each later enable cycle starts from a flushed filter. The first N decimated results after an enable are dropped while the filter settles. A reserved ratio or order code keeps the block silent for the whole enable period.

Top module: `sinc_decim`

## Requirements
- R1: An input bit of 1 counts as +1 and a bit of 0 counts as -1. A constant stream of ones gives pcm_o = 0x7FFFFF and a constant stream of zeros gives pcm_o = 0x800000 (-8388608).
- R2: order_i values 1 to 5 select N. ratio_code_i values 1 to 6 select R = 2^(code+2), so code 1 = 8, 2 = 16, 3 = 32, 4 = 64, 5 = 128, 6 = 256. One decimated result is produced for every R accepted bits.
- R3: Decimated result m equals the N-fold cascade of length-R moving sums of the mapped input, taken at accepted bit index mR-1. All history before the enable counts as zero.
- R4: The result is multiplied by 2^(23 - N*log2(R)), using an arithmetic right shift (floor) when that exponent is negative, and then saturated to the signed 24-bit range.
- R5: The first N decimated results after an enable are suppressed. Result N+1 is the first that reaches pcm_o.
- R6: Ratio code 0 or 7 to 15, or order 0 or 6 to 15, sampled at enable, produces no pcm_valid_o pulse for the whole enable period.
- R7: order_i and ratio_code_i are sampled only in the cycle where en_i rises. Changes while enabled have no effect until en_i has been low and rises again.
- R8: A low en_i clears all integrator, comb, decimation and settling state and gives no output. The next enable starts from zero history.
- R9: A bit is accepted only when pdm_valid_i is high in a cycle where en_i is high and was also high in the previous cycle. A bit presented in the cycle en_i rises is ignored.
- R10: pcm_valid_o is a one-cycle pulse in the cycle after the clock edge that accepts the R-th bit. pcm_o holds its value between pulses.
- R11: After reset, pcm_o is 0 and pcm_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; rising edge loads settings and flushes the filter |
| order_i | input | 4 | Filter order field |
| ratio_code_i | input | 4 | Decimation ratio code field |
| pdm_i | input | 1 | Pulse-density data bit |
| pdm_valid_i | input | 1 | Data bit strobe |
| pcm_o | output | 24 | Signed PCM sample |
| pcm_valid_o | output | 1 | One-cycle sample strobe |

## Verification
Some properties hold on every cycle, and the bound checker watches them. There is no output while disabled, in the cycle the enable rises, or under a reserved setting. Strobes are never back to back and always follow an accepted bit. The sample value is stable between strobes. Sample values, the settling discard, the scaling for each order and ratio pair, and the fact that mid-run setting changes are ignored all depend on history. Only the bench shows these, by comparing every strobe against a moving-sum reference model and counting strobes per run.

// File: rtl/sinc_decim_pkg.sv
package sinc_decim_pkg;
  localparam int ORDER_W       = 4;
  localparam int CODE_W        = 4;
  localparam int RESET_ORDER   = 3;
  localparam int CODE_LOG_BIAS = 2;

  typedef struct packed {
    logic [ORDER_W-1:0] order;
    logic [CODE_W-1:0]  code;
  } sinc_cfg_t;

  function automatic int code_to_log(logic [CODE_W-1:0] code);
    return int'(code) + CODE_LOG_BIAS;
  endfunction
endpackage

// File: rtl/sinc_integ.sv
module sinc_integ
  import sinc_decim_pkg::*;
#(
  parameter int MAX_ORDER = 5,
  parameter int ACC_W     = 42
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    step_i,
  input  logic [ORDER_W-1:0]      order_i,
  input  logic signed [ACC_W-1:0] sample_i,
  output logic signed [ACC_W-1:0] sum_o
);
  logic signed [ACC_W-1:0] chain [MAX_ORDER+1];

  assign chain[0] = sample_i;

  for (genvar k = 0; k < MAX_ORDER; k++) begin : g_stage
    logic signed [ACC_W-1:0] acc_q;
    logic                    act;
    assign act          = int'(order_i) > k;
    // unused stages pass through so the tap is always the last one
    assign chain[k+1]   = act ? acc_q + chain[k] : chain[k];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             acc_q <= '0;
      else if (clear_i)        acc_q <= '0;
      else if (step_i && act)  acc_q <= chain[k+1];
    end
  end

  assign sum_o = chain[MAX_ORDER];
endmodule

// File: rtl/sinc_comb.sv
module sinc_comb
  import sinc_decim_pkg::*;
#(
  parameter int MAX_ORDER = 5,
  parameter int ACC_W     = 42
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    step_i,
  input  logic [ORDER_W-1:0]      order_i,
  input  logic signed [ACC_W-1:0] data_i,
  output logic signed [ACC_W-1:0] data_o
);
  logic signed [ACC_W-1:0] chain [MAX_ORDER+1];

  assign chain[0] = data_i;

  for (genvar k = 0; k < MAX_ORDER; k++) begin : g_stage
    logic signed [ACC_W-1:0] dly_q;
    logic                    act;
    assign act        = int'(order_i) > k;
    assign chain[k+1] = act ? chain[k] - dly_q : chain[k];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             dly_q <= '0;
      else if (clear_i)        dly_q <= '0;
      else if (step_i && act)  dly_q <= chain[k];
    end
  end

  assign data_o = chain[MAX_ORDER];
endmodule

// File: rtl/sinc_scale.sv
module sinc_scale
  import sinc_decim_pkg::*;
#(
  parameter int ACC_W = 42,
  parameter int OUT_W = 24
) (
  input  logic [ORDER_W-1:0]      order_i,
  input  logic [CODE_W-1:0]       code_i,
  input  logic signed [ACC_W-1:0] data_i,
  output logic signed [OUT_W-1:0] data_o
);
  localparam int FS_EXP = OUT_W - 1;
  localparam logic signed [ACC_W-1:0] POS_LIM = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] NEG_LIM = {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  int                      gain_exp;
  logic signed [ACC_W-1:0] wide;

  always_comb begin
    gain_exp = int'(order_i) * code_to_log(code_i);
    if (gain_exp >= FS_EXP) wide = data_i >>> (gain_exp - FS_EXP);
    else                    wide = data_i <<< (FS_EXP - gain_exp);
    // only +full scale can exceed the range
    if (wide > POS_LIM)      data_o = POS_LIM[OUT_W-1:0];
    else if (wide < NEG_LIM) data_o = NEG_LIM[OUT_W-1:0];
    else                     data_o = wide[OUT_W-1:0];
  end
endmodule

// File: rtl/sinc_decim.sv
module sinc_decim
  import sinc_decim_pkg::*;
#(
  parameter int MAX_ORDER = 5,
  parameter int MAX_LOG   = 8,
  parameter int OUT_W     = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [ORDER_W-1:0] order_i,
  input  logic [CODE_W-1:0]  ratio_code_i,
  input  logic               pdm_i,
  input  logic               pdm_valid_i,
  output logic [OUT_W-1:0]   pcm_o,
  output logic               pcm_valid_o
);
  localparam int ACC_W    = MAX_ORDER * MAX_LOG + 2;
  localparam int CNT_W    = MAX_LOG;
  localparam int MAX_CODE = MAX_LOG - CODE_LOG_BIAS;

  sinc_cfg_t               cfg_q;
  logic                    run_q, cfg_ok_q, pcm_vld_q;
  logic [CNT_W-1:0]        cnt_q, cnt_last;
  logic [ORDER_W-1:0]      settle_q;
  logic [OUT_W-1:0]        pcm_q;
  logic                    start, clear, accept, tick, cfg_ok_in, settled;
  logic signed [ACC_W-1:0] sample, integ_sum, comb_out;
  logic signed [OUT_W-1:0] scaled;

  assign start     = en_i & ~run_q;
  assign clear     = ~en_i | start;
  assign cfg_ok_in = (order_i != '0) && (int'(order_i) <= MAX_ORDER) &&
                     (ratio_code_i != '0) && (int'(ratio_code_i) <= MAX_CODE);
  assign cnt_last  = CNT_W'((1 << code_to_log(cfg_q.code)) - 1);
  assign accept    = run_q & en_i & pdm_valid_i & cfg_ok_q;
  assign tick      = accept & (cnt_q == cnt_last);
  assign settled   = settle_q == cfg_q.order;
  assign sample    = pdm_i ? ACC_W'(1) : {ACC_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      cfg_q    <= '{order: ORDER_W'(RESET_ORDER), code: '0};
      cfg_ok_q <= 1'b0;
    end else begin
      run_q <= en_i;
      if (start) begin
        cfg_q    <= '{order: order_i, code: ratio_code_i};
        cfg_ok_q <= cfg_ok_in;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      settle_q <= '0;
    end else if (clear) begin
      cnt_q    <= '0;
      settle_q <= '0;
    end else if (accept) begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick && !settled) settle_q <= settle_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcm_q     <= '0;
      pcm_vld_q <= 1'b0;
    end else begin
      pcm_vld_q <= tick & settled;
      if (tick && settled) pcm_q <= scaled;
    end
  end

  sinc_integ #(.MAX_ORDER(MAX_ORDER), .ACC_W(ACC_W)) u_integ (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear),
    .step_i   (accept),
    .order_i  (cfg_q.order),
    .sample_i (sample),
    .sum_o    (integ_sum)
  );

  sinc_comb #(.MAX_ORDER(MAX_ORDER), .ACC_W(ACC_W)) u_comb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .step_i  (tick),
    .order_i (cfg_q.order),
    .data_i  (integ_sum),
    .data_o  (comb_out)
  );

  sinc_scale #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_scale (
    .order_i (cfg_q.order),
    .code_i  (cfg_q.code),
    .data_i  (comb_out),
    .data_o  (scaled)
  );

  assign pcm_o       = pcm_q;
  assign pcm_valid_o = pcm_vld_q;
endmodule

// File: rtl/sinc_decim_chk.sv
module sinc_decim_chk #(
  parameter int OUT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             pdm_valid_i,
  input logic             run_q,
  input logic             cfg_ok_q,
  input logic [OUT_W-1:0] pcm_o,
  input logic             pcm_valid_o
);
  p_quiet_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pcm_valid_o);

  p_quiet_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !run_q) |=> !pcm_valid_o);

  p_bad_cfg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_ok_q |=> !pcm_valid_o);

  p_single_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcm_valid_o |=> !pcm_valid_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pcm_valid_o |-> $stable(pcm_o));

  p_after_input_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcm_valid_o |-> $past(pdm_valid_i && en_i && run_q));
endmodule

bind sinc_decim sinc_decim_chk #(.OUT_W(OUT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .pdm_valid_i (pdm_valid_i),
  .run_q       (run_q),
  .cfg_ok_q    (cfg_ok_q),
  .pcm_o       (pcm_o),
  .pcm_valid_o (pcm_valid_o)
);

// File: tb/sinc_decim_tb.sv
`timescale 1ns/1ps
module sinc_decim_tb;
  localparam int HIST = 4096;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [3:0]  order_i = '0;
  logic [3:0]  ratio_code_i = '0;
  logic        pdm_i = 1'b0;
  logic        pdm_valid_i = 1'b0;
  logic [23:0] pcm_o;
  logic        pcm_valid_o;

  always #2.5 clk = ~clk;

  sinc_decim u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .order_i      (order_i),
    .ratio_code_i (ratio_code_i),
    .pdm_i        (pdm_i),
    .pdm_valid_i  (pdm_valid_i),
    .pcm_o        (pcm_o),
    .pcm_valid_o  (pcm_valid_o)
  );

  int     checks = 0;
  int     fails = 0;
  bit     done = 1'b0;
  longint st [0:5][0:HIST-1];
  int     cnt, oidx, b_n, b_l, seen, exp_pulses;
  bit     b_ok, b_run, exp_v;
  longint exp_val;
  logic [23:0] last_pcm = '0;
  string  cur_tag = "R11";

  task automatic fail(input string tag, input string what, input longint act, input longint expv);
    fails++;
    $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
  endtask

  function automatic longint scale_ref(input longint y, input int s);
    longint r;
    if (s >= 23) r = y >>> (s - 23);
    else         r = y <<< (23 - s);
    if (r > 64'sd8388607)       r = 64'sd8388607;
    else if (r < -64'sd8388608) r = -64'sd8388608;
    return r;
  endfunction

  task automatic step(input bit en, input bit v, input bit b, input int ord, input int code);
    bit acc;
    int r;
    @(negedge clk);
    if (pcm_valid_o !== exp_v) fail("R10", "strobe", longint'(pcm_valid_o), longint'(exp_v));
    else if (exp_v) begin
      checks++;
      if (longint'($signed(pcm_o)) != exp_val) fail(cur_tag, "sample", longint'($signed(pcm_o)), exp_val);
    end
    if (pcm_valid_o === 1'b1) begin
      seen++;
      last_pcm = pcm_o;
    end else begin
      checks++;
      if (pcm_o !== last_pcm) fail("R10", "hold", longint'(pcm_o), longint'(last_pcm));
    end
    en_i = en; pdm_valid_i = v; pdm_i = b;
    order_i = 4'(ord); ratio_code_i = 4'(code);
    exp_v = 1'b0;
    acc = en && b_run && v && b_ok;
    if (en && !b_run) begin
      b_n = ord; b_l = code + 2;
      b_ok = (ord >= 1 && ord <= 5 && code >= 1 && code <= 6);
      cnt = 0; oidx = 0;
    end
    if (!en) begin cnt = 0; oidx = 0; end
    b_run = en;
    if (acc && cnt < HIST) begin
      r = 1 << b_l;
      st[0][cnt] = b ? 64'sd1 : -64'sd1;
      for (int k = 1; k <= b_n; k++)
        st[k][cnt] = (cnt > 0 ? st[k][cnt-1] : 0) + st[k-1][cnt] - (cnt >= r ? st[k-1][cnt-r] : 0);
      cnt++;
      if (cnt % r == 0) begin
        oidx++;
        if (oidx > b_n) begin
          exp_v = 1'b1;
          exp_val = scale_ref(st[b_n][cnt-1], b_n * b_l);
          exp_pulses++;
        end
      end
    end
  endtask

  // mode: 0 random bits with gaps, 1 ones, 2 zeros, 3 random bits no gaps
  task automatic run_cfg(input int ord, input int code, input int nin, input int mode,
                         input int ord2, input int code2, input bit vstart, input int want,
                         input string tag);
    int fed = 0;
    bit v, b;
    cur_tag = tag; seen = 0; exp_pulses = 0;
    step(1, vstart, 1, ord, code);
    while (fed < nin) begin
      v = (mode == 0) ? (($urandom % 4) != 0) : 1'b1;
      b = (mode == 1) ? 1'b1 : (mode == 2) ? 1'b0 : 1'($urandom % 2);
      if (fed < nin / 2) step(1, v, b, ord, code);
      else               step(1, v, b, ord2, code2);
      if (v) fed++;
    end
    step(1, 0, 0, ord2, code2);
    step(1, 0, 0, ord2, code2);
    step(0, 0, 0, ord2, code2);
    step(0, 0, 0, ord2, code2);
    checks++;
    if (seen != exp_pulses) fail(tag, "strobe count", seen, exp_pulses);
    if (want >= 0) begin
      checks++;
      if (seen != want) fail(tag, "strobe count fixed", seen, want);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    b_run = 0; b_ok = 0; exp_v = 0; cnt = 0; oidx = 0; b_n = 0; b_l = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    checks++; if (pcm_valid_o !== 1'b0) fail("R11", "reset strobe", longint'(pcm_valid_o), 0);
    checks++; if (pcm_o !== 24'h0) fail("R11", "reset sample", longint'(pcm_o), 0);

    run_cfg(1, 1, 8*8,   1, 1, 1, 0, 7, "R1");     // ones: +full scale, saturated (R4)
    run_cfg(3, 2, 16*6,  2, 3, 2, 0, 3, "R1");     // zeros: -full scale
    run_cfg(4, 1, 8*7,   1, 4, 1, 0, 3, "R5");     // 7 results, 4 settle
    run_cfg(2, 6, 256*4, 3, 2, 6, 0, 2, "R4");     // gain below full scale, left shift
    run_cfg(5, 6, 256*7, 0, 5, 6, 0, 2, "R3");     // widest gain, right shift
    run_cfg(2, 3, 32*6,  0, 2, 3, 0, 4, "R2");
    run_cfg(3, 0, 200,   0, 3, 0, 0, 0, "R6");     // ratio code 0
    run_cfg(3, 7, 200,   0, 3, 7, 0, 0, "R6");     // reserved ratio
    run_cfg(0, 1, 200,   0, 0, 1, 0, 0, "R6");     // order 0
    run_cfg(6, 1, 200,   0, 6, 1, 0, 0, "R6");     // order 6
    run_cfg(2, 1, 8*10,  0, 5, 6, 0, 8, "R7");     // mid-run change ignored
    run_cfg(3, 1, 8*5+5, 3, 3, 1, 0, 2, "R8");     // partial block then disable
    run_cfg(3, 1, 8*6,   3, 3, 1, 0, 3, "R8");     // restart from zero history
    run_cfg(1, 1, 8*3,   1, 1, 1, 1, 2, "R9");     // bit in enable cycle ignored
    for (int i = 0; i < 8; i++) begin
      int o, c;
      o = 1 + int'($urandom % 5);
      c = 1 + int'($urandom % 6);
      run_cfg(o, c, (o + 3) * (1 << (c + 2)), 0, o, c, 0, 3, "R3");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule